// File: doc/BRIEF.md
# Flag-Mask Conditional Branch Unit

This block is the execute step for a 32-bit relative branch. After fetch has already advanced the program counter, the block receives the instruction word, the four status flags (carry, zero, negative, overflow), the program counter and the stack pointer. It then decides whether the branch is taken and returns the next program counter. There is no decoder per mnemonic. A 9-bit mask picks any subset of nine flag terms. The picked terms are ORed together, and the result is compared with a polarity bit. Signed comparisons use the N XOR V term.

In the subroutine form, a taken branch first saves the return address on a stack that grows downward in memory, and only then jumps. The memory side is a write port that completes in one cycle. The controller is a four-state machine:

- **ST_IDLE** waits for `start`. On a start with a branch opcode, it takes one of two transitions:
  - **go_done** for a plain branch, or for any branch that is not taken.
  - **go_push** for a taken subroutine branch.
- **ST_DEC** shows the decremented stack pointer and the push address. It always takes **dec_to_write**.
- **ST_WRITE** strobes the memory write. It always takes **write_to_done**.
- **ST_DONE** pulses `done`. It always takes **done_to_idle**.

Top module: `brcond_unit`

## Requirements
- R1: Reset state. While `rst_n` is low, and after it is released, `pc_out`, `sp_out`, `mem_addr` and `mem_wdata` are zero, and `done`, `mem_we` and `taken` are low.
- R2: Opcode gate. A `start` is accepted only when `instr[31:28]` is 4'b0111 and `instr[27]` is 1. Any other word at `start` produces no `done` and leaves `pc_out` unchanged.
- R3: Condition mask. `instr[24:16]` is a mask over the following terms, one bit each:

  | Mask bit | Term |
  |---|---|
  | `instr[24]` | C |
  | `instr[23]` | ~C |
  | `instr[22]` | Z |
  | `instr[21]` | ~Z |
  | `instr[20]` | N |
  | `instr[19]` | ~N |
  | `instr[18]` | V |
  | `instr[17]` | ~V |
  | `instr[16]` | N^V |

  The branch is taken when the OR of the masked terms equals the polarity bit `instr[25]`. Several set mask bits combine by OR.
- R4: Signed compares. The following settings decide taken exactly as the compare requires:

  | Compare | Mask | Polarity |
  |---|---|---|
  | less | N^V only | 1 |
  | greater-or-equal | N^V only | 0 |
  | less-or-equal | Z and N^V | 1 |
  | greater | Z and N^V | 0 |

- R5: Empty mask. An all-zero mask with polarity 0 is always taken. An all-zero mask with polarity 1 is never taken.
- R6: Target. When taken, `pc_out` becomes `pc_in` plus the sign-extended `instr[15:0]`, modulo 2^24. When not taken, `pc_out` becomes `pc_in`.
- R7: Plain timing. For a plain branch (`instr[26]`=0), and for any branch that is not taken, `done` is high for exactly the one cycle after the accepting edge. `taken`, `pc_out` and `sp_out` are valid in that cycle, and `sp_out` equals `sp_in`.
- R8: Subroutine push. A taken branch with `instr[26]`=1 runs through three cycles:
  - Cycle 1 shows `sp_out` = `mem_addr` = `sp_in`-1.
  - Cycle 2 holds `mem_we` high for that one cycle, with `mem_wdata` = {8'h00, `pc_in`}.
  - Cycle 3 pulses `done` with `pc_out` = target.
- R9: Subroutine not taken. A subroutine branch whose condition fails does no write, keeps `sp_out` = `sp_in`, and completes like a plain branch.
- R10: Busy. A `start` during a sequence that is already running is ignored.
- R11: Stack wrap. Pushing with `sp_in` = 0 writes at address 24'hFFFFFF and leaves `sp_out` = 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to execute `instr` |
| instr | input | 32 | Instruction word; bit 31 is field bit 0 |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| pc_in | input | 24 | Program counter, already incremented |
| sp_in | input | 24 | Stack pointer |
| pc_out | output | 24 | Next program counter |
| sp_out | output | 24 | Updated stack pointer |
| taken | output | 1 | Branch decision, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |

## Verification
The bench steers each mask term and each signed-compare pair to both outcomes, so a term wired to the wrong flag, or a polarity that is inverted, shows up as a wrong `taken` and a wrong target. Negative displacements and wrap at the top of the address space catch an adder that zero-extends or drops the carry. Subroutine pushes with `sp_in` = 0 and with a failing condition catch an address taken before the decrement, a write that is not gated by the decision, and a stack pointer that changes when no push happened. Non-branch words, and a second start during a push, look for an FSM that accepts work it should refuse; such an FSM would produce an extra `done` or a changed `pc_out`.

// File: rtl/brc_pkg.sv
package brc_pkg;
    localparam int MASK_W = 9;
    localparam logic [3:0] BR_OPCODE = 4'b0111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DEC,
        ST_WRITE,
        ST_DONE
    } brc_state_e;
endpackage

// File: rtl/brc_cond.sv
module brc_cond
    import brc_pkg::*;
(
    input  logic              c,
    input  logic              z,
    input  logic              n,
    input  logic              v,
    input  logic [MASK_W-1:0] mask,
    input  logic              pol,
    output logic              take
);
    logic [MASK_W-1:0] terms;
    logic [MASK_W-1:0] hits;

    // mask[8] selects the first term (C) ... mask[0] the last (N^V)
    assign terms = {c, ~c, z, ~z, n, ~n, v, ~v, n ^ v};

    for (genvar k = 0; k < MASK_W; k++) begin : g_hit
        assign hits[k] = mask[k] & terms[k];
    end

    assign take = ((|hits) == pol);
endmodule

// File: rtl/brc_target.sv
module brc_target #(
    parameter int ADDR_W = 24,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign target   = pc + disp_ext;
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
    import brc_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 32,
    parameter int DISP_W  = 16,
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic               flag_c,
    input  logic               flag_z,
    input  logic               flag_n,
    input  logic               flag_v,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [ADDR_W-1:0]  sp_in,
    output logic [ADDR_W-1:0]  pc_out,
    output logic [ADDR_W-1:0]  sp_out,
    output logic               taken,
    output logic               done,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_we
);
    // field bit k (counted from the MSB) sits at instr[INSTR_W-1-k]
    localparam int B_OPC_HI = INSTR_W - 1;
    localparam int B_LONG   = INSTR_W - 5;
    localparam int B_SUB    = INSTR_W - 6;
    localparam int B_POL    = INSTR_W - 7;
    localparam int B_MASK   = INSTR_W - 8;
    localparam int PAD_W    = DATA_W - ADDR_W;

    brc_state_e state, state_n;

    logic              is_branch;
    logic              is_sub;
    logic              cond_ok;
    logic              accept;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] jump_q;

    assign is_branch = (instr[B_OPC_HI -: 4] == BR_OPCODE) && instr[B_LONG];
    assign is_sub    = instr[B_SUB];
    assign accept    = (state == ST_IDLE) && start && is_branch;

    brc_cond u_cond (
        .c    (flag_c),
        .z    (flag_z),
        .n    (flag_n),
        .v    (flag_v),
        .mask (instr[B_MASK -: MASK_W]),
        .pol  (instr[B_POL]),
        .take (cond_ok)
    );

    brc_target #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_target (
        .pc     (pc_in),
        .disp   (instr[DISP_W-1:0]),
        .target (target)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_n = (is_sub && cond_ok) ? ST_DEC : ST_DONE;
                end
            end
            ST_DEC:   state_n = ST_WRITE;
            ST_WRITE: state_n = ST_DONE;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // registered datapath outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_out    <= '0;
            sp_out    <= '0;
            taken     <= 1'b0;
            jump_q    <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        taken <= cond_ok;
                        if (is_sub && cond_ok) begin
                            sp_out    <= sp_in - ADDR_W'(1);
                            mem_addr  <= sp_in - ADDR_W'(1);
                            mem_wdata <= {{PAD_W{1'b0}}, pc_in};
                            jump_q    <= target;
                        end else begin
                            sp_out <= sp_in;
                            pc_out <= cond_ok ? target : pc_in;
                        end
                    end
                end
                ST_WRITE: pc_out <= jump_q;
                default: ;
            endcase
        end
    end

    // state-decoded strobes
    always_comb begin
        mem_we = (state == ST_WRITE);
        done   = (state == ST_DONE);
    end
endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] sp_out,
    input logic [DATA_W-1:0] mem_wdata
);
    localparam int PAD_W = DATA_W - ADDR_W;

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the write strobe lasts one cycle
    p_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R8: done follows the write in the very next cycle
    p_we_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done);

    // R11: the write goes to the decremented stack pointer
    p_push_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == sp_out));

    // R8: the pushed return address is zero-extended
    p_push_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[DATA_W-1 -: PAD_W] == '0));

    // R8: the stack pointer does not move between the write and done
    p_sp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(sp_out));
endmodule

bind brcond_unit brcond_unit_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_brcond_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .sp_out    (sp_out),
    .mem_wdata (mem_wdata)
);

// File: tb/brcond_unit_bench.sv
`timescale 1ns/1ps
module brcond_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        flag_c = 1'b0, flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0;
    logic [23:0] pc_in = '0, sp_in = '0;
    logic [23:0] pc_out, sp_out, mem_addr;
    logic [31:0] mem_wdata;
    logic        taken, done, mem_we;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    typedef struct {
        logic [23:0] pc;
        logic [23:0] sp;
        logic        tk;
        logic        push;
        logic [23:0] paddr;
        logic [31:0] pdata;
        int          dcyc;
        string       tag;
    } exp_t;

    exp_t q[$];

    logic        seen_push = 1'b0;
    logic [23:0] seen_addr = '0;
    logic [31:0] seen_data = '0;

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    brcond_unit u_brcond_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .instr     (instr),
        .flag_c    (flag_c),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_v    (flag_v),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .pc_out    (pc_out),
        .sp_out    (sp_out),
        .taken     (taken),
        .done      (done),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic sub, input logic pol,
                                       input logic [8:0] mask, input logic [15:0] disp);
        return {4'b0111, 1'b1, sub, pol, mask, disp};
    endfunction

    // Condition model from the requirement text: term k is selected by instr[24-k]
    function automatic logic model_take(input logic [31:0] w, input logic c,
                                        input logic z, input logic n, input logic v);
        logic hit = 1'b0;
        for (int k = 0; k < 9; k++) begin
            logic t;
            case (k)
                0: t = c;
                1: t = !c;
                2: t = z;
                3: t = !z;
                4: t = n;
                5: t = !n;
                6: t = v;
                7: t = !v;
                default: t = n ^ v;
            endcase
            if (w[24-k] && t) hit = 1'b1;
        end
        return hit == w[25];
    endfunction

    // Driver: applies one branch and queues the expected outcome
    task automatic run_br(input logic [31:0] w, input logic c, input logic z,
                          input logic n, input logic v, input logic [23:0] pc,
                          input logic [23:0] sp, input string tag);
        exp_t e;
        logic tk;
        logic psh;
        int   lat;
        @(negedge clk);
        tk  = model_take(w, c, z, n, v);
        psh = tk && w[26];
        lat = psh ? 3 : 1;
        e.tk    = tk;
        e.push  = psh;
        e.pc    = tk ? pc + {{8{w[15]}}, w[15:0]} : pc;
        e.sp    = psh ? sp - 24'd1 : sp;
        e.paddr = sp - 24'd1;
        e.pdata = {8'h00, pc};
        e.dcyc  = cyc + lat;
        e.tag   = tag;
        q.push_back(e);
        instr = w; flag_c = c; flag_z = z; flag_n = n; flag_v = v;
        pc_in = pc; sp_in = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (lat + 1) @(negedge clk);
    endtask

    // Monitor: pops expectations as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_we) begin
                if (seen_push) chk(1'b0, "R8 double write", 32'd1, 32'd0);
                seen_push = 1'b1;
                seen_addr = mem_addr;
                seen_data = mem_wdata;
            end
            if (rst_n && done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2/R10 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(pc_out == e.pc, {e.tag, " pc_out"}, {8'h0, pc_out}, {8'h0, e.pc});
                    chk(sp_out == e.sp, {e.tag, " sp_out"}, {8'h0, sp_out}, {8'h0, e.sp});
                    chk(taken == e.tk, {e.tag, " taken"}, {31'h0, taken}, {31'h0, e.tk});
                    chk(cyc == e.dcyc, {e.tag, " done cycle R7/R8"}, cyc, e.dcyc);
                    chk(seen_push == e.push, {e.tag, " push seen"},
                        {31'h0, seen_push}, {31'h0, e.push});
                    if (e.push) begin
                        chk(seen_addr == e.paddr, {e.tag, " push addr R8"},
                            {8'h0, seen_addr}, {8'h0, e.paddr});
                        chk(seen_data == e.pdata, {e.tag, " push data R8"},
                            seen_data, e.pdata);
                    end
                end
                seen_push = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] hold;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pc_out == 0 && sp_out == 0 && mem_addr == 0, "R1 reset regs",
            {8'h0, pc_out | sp_out | mem_addr}, 32'h0);
        chk(!done && !mem_we && !taken && mem_wdata == 0, "R1 reset strobes",
            {29'h0, done, mem_we, taken}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_out == 0 && !done && !mem_we, "R1 after release",
            {8'h0, pc_out}, 32'h0);

        // R3 / R6: single terms, both outcomes, positive and negative displacement
        run_br(mk(0, 1, 9'b001000000, 16'h0010), 0, 1, 0, 0, 24'h000100, 24'h000400, "R3 Z set");
        run_br(mk(0, 1, 9'b000100000, 16'h0010), 0, 1, 0, 0, 24'h000100, 24'h000400, "R3 notZ");
        run_br(mk(0, 1, 9'b100000000, 16'hFFF0), 1, 0, 0, 0, 24'h000010, 24'h000400, "R6 negative disp");
        run_br(mk(0, 1, 9'b010000000, 16'h0020), 1, 0, 0, 0, 24'h000010, 24'h000400, "R3 notC");
        run_br(mk(0, 1, 9'b000010000, 16'h0020), 0, 0, 1, 0, 24'h000010, 24'h000400, "R3 N");
        run_br(mk(0, 1, 9'b000000010, 16'h0020), 0, 0, 0, 0, 24'h000010, 24'h000400, "R3 notV");
        run_br(mk(0, 0, 9'b000001000, 16'h0020), 0, 0, 1, 0, 24'h000010, 24'h000400, "R3 pol0 notN");
        // R6: wrap modulo 2^24
        run_br(mk(0, 1, 9'b000000100, 16'h0020), 0, 0, 0, 1, 24'hFFFFF0, 24'h000400, "R6 wrap");
        // R3: two mask bits OR together
        run_br(mk(0, 1, 9'b100000100, 16'h0004), 0, 0, 0, 1, 24'h000200, 24'h000400, "R3 C|V");
        run_br(mk(0, 1, 9'b100000100, 16'h0004), 0, 0, 0, 0, 24'h000200, 24'h000400, "R3 C|V clear");
        // R4: signed compares
        run_br(mk(0, 1, 9'b000000001, 16'h0040), 0, 0, 1, 0, 24'h001000, 24'h000400, "R4 less");
        run_br(mk(0, 0, 9'b000000001, 16'h0040), 0, 0, 1, 1, 24'h001000, 24'h000400, "R4 ge");
        run_br(mk(0, 1, 9'b001000001, 16'h0040), 0, 1, 0, 0, 24'h001000, 24'h000400, "R4 le");
        run_br(mk(0, 0, 9'b001000001, 16'h0040), 0, 1, 0, 0, 24'h001000, 24'h000400, "R4 gt on equal");
        run_br(mk(0, 0, 9'b001000001, 16'h0040), 0, 0, 0, 0, 24'h001000, 24'h000400, "R4 gt");
        // R5: empty mask
        run_br(mk(0, 0, 9'b0, 16'h8000), 1, 1, 1, 1, 24'h009000, 24'h000400, "R5 always");
        run_br(mk(0, 1, 9'b0, 16'h8000), 1, 1, 1, 1, 24'h009000, 24'h000400, "R5 never");
        // R8: subroutine push
        run_br(mk(1, 0, 9'b0, 16'h0100), 0, 0, 0, 0, 24'h001234, 24'h000800, "R8 push");
        // R9: subroutine not taken
        run_br(mk(1, 1, 9'b001000000, 16'h0100), 0, 0, 0, 0, 24'h001234, 24'h000800, "R9 no push");
        // R11: stack wrap
        run_br(mk(1, 1, 9'b100000000, 16'hFFFE), 1, 0, 0, 0, 24'h000050, 24'h000000, "R11 sp wrap");

        // R2: non-branch words are ignored
        @(negedge clk);
        hold = pc_out;
        instr = 32'h6FFF_0010; pc_in = 24'h00ABCD; start = 1'b1;
        @(negedge clk);
        instr = {4'b0111, 1'b0, 27'h0000010};
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(pc_out == hold, "R2 ignored opcode", {8'h0, pc_out}, {8'h0, hold});

        // R10: start during a push is ignored
        run_br_busy();
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10 queue drained", q.size(), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic run_br_busy();
        exp_t e;
        @(negedge clk);
        e.tk = 1'b1; e.push = 1'b1;
        e.pc = 24'h002010; e.sp = 24'h0003FF;
        e.paddr = 24'h0003FF; e.pdata = 32'h0000_2000;
        e.dcyc = cyc + 3; e.tag = "R10 busy";
        q.push_back(e);
        instr = mk(1, 0, 9'b0, 16'h0010); pc_in = 24'h002000; sp_in = 24'h000400;
        start = 1'b1;
        @(negedge clk);
        instr = mk(0, 0, 9'b0, 16'h0500); pc_in = 24'h007000; sp_in = 24'h000100;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask
endmodule